// File: doc/BRIEF.md
# SDRAM Bring-up and Refresh Sequencer

This block sits on the controller side of a synchronous DRAM interface. It takes the memory from reset to an operational state and then keeps it refreshed. Straight after reset it owns the command pins. It keeps the clock enable asserted, forces every data mask high and sends only no-operation commands for a long stabilisation period. It then steps through a fixed series of commands: one precharge of all banks, a programmable number of auto-refresh commands, and one mode register load that carries a parameterised mode word. The required spacing is enforced between every pair of these commands. Once the mode load has settled, the block raises `ready` and releases the masks.

From that point a refresh interval timer raises a request towards the system's command arbiter. When the arbiter answers with a grant, the block drives an auto-refresh command in the next cycle. It then holds off any further request for the refresh cycle time. Requests that the arbiter does not serve build up in a backlog counter of bounded depth. A sticky overrun flag reports that the backlog limit was exceeded. Every delay is a parameter counted in clock cycles, so a simulation can use shortened values.

Top module: `sdram_bringup`

## Requirements
- R1: While reset is asserted and directly after it, the command is NOP (chip select 0, row, column and write strobes 1). `cmd_cke` is 1, every `cmd_dqm` bit is 1, and `ready`, `ref_req` and `ref_overrun` are 0.
- R2: After reset is released the block drives NOP for exactly `STAB_CYC` cycles. On the `STAB_CYC`-th clock edge it drives a precharge (strobes row 0, column 1, write 0) with address bit 10 at 1, which selects all banks.
- R3: The first auto-refresh (strobes row 0, column 0, write 1) follows the precharge by exactly `TRP_CYC` cycles.
- R4: Exactly `INIT_REFS` auto-refresh commands are issued during bring-up, each `TRFC_CYC` cycles after the one before, with NOP in between.
- R5: `TRFC_CYC` cycles after the last bring-up refresh, one mode register load is issued (all strobes 0). `MODE_VALUE` is on address bits 9..0, and the higher address bits and the bank address are 0.
- R6: `ready` rises exactly `TRSC_CYC` cycles after the mode load and stays high until reset. `cmd_dqm` is all ones before `ready` and all zeros from then on.
- R7: `cmd_cke` is 1 in every cycle.
- R8: `ref_req` first rises `REF_INTERVAL` cycles after `ready` rises. It stays high, cycle after cycle, until the arbiter grants it.
- R9: A cycle with `ref_req` and `ref_gnt` both high is followed by an auto-refresh command in the next cycle. `ref_req` then stays low for `TRFC_CYC` cycles, so two refreshes issued in running mode are at least `TRFC_CYC + 1` cycles apart.
- R10: Each `REF_INTERVAL` period adds one refresh to the backlog, up to `MISS_MAX`. Each grant serves exactly one, and `ref_req` is high whenever the backlog is non-zero and no refresh is recovering.
- R11: A period that ends while `MISS_MAX` refreshes are already owed sets `ref_overrun`. The flag stays set until reset, and the backlog stays at `MISS_MAX`.
- R12: `ref_gnt` has no effect while `ref_req` is low, during bring-up and in running mode alike. The command stays NOP and the refresh schedule is unchanged.
- R13: Asserting reset at any point, even in the middle of bring-up, returns the outputs to the R1 state. After release the whole sequence runs again from the stabilisation wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Arbiter grants the pending refresh request |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write strobe, active low |
| cmd_cke | output | 1 | Clock enable to the memory |
| cmd_addr | output | ADDR_W | Address bus (precharge-all bit, mode word) |
| cmd_ba | output | BA_W | Bank address |
| cmd_dqm | output | DQM_W | Data masks |
| ready | output | 1 | Bring-up complete |
| ref_req | output | 1 | Refresh request to the arbiter |
| ref_overrun | output | 1 | Sticky flag: refresh backlog exceeded its limit |

## Verification
The bench compares every cycle of the bring-up against the expected command schedule. A design with an off-by-one in any wait would shift the precharge, a refresh or the mode load by one cycle. A design with a wrong refresh count would issue one refresh too many or too few before the mode load. Grants are held high through bring-up and before the first request, which catches a design that refreshes or moves its schedule on an unrequested grant. Backlog tests let three periods, and then nine, go unserved: an unbounded or wrongly saturating backlog would show up as a missing or late overrun flag or as the wrong number of refreshes served. A reset in the middle of the refresh phase catches state that survives reset.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_PREA = 2'd1,
        CMD_REFA = 2'd2,
        CMD_MRS  = 2'd3
    } cmd_e;

    typedef enum logic [2:0] {
        ST_STAB     = 3'd0,
        ST_PRE_WAIT = 3'd1,
        ST_REF_WAIT = 3'd2,
        ST_MRS_WAIT = 3'd3,
        ST_RUN      = 3'd4,
        ST_RUN_REC  = 3'd5
    } state_e;

endpackage

// File: rtl/sdinit_cmd_enc.sv
module sdinit_cmd_enc
    import sdinit_pkg::*;
(
    input  cmd_e cmd,
    output logic cs_n,
    output logic ras_n,
    output logic cas_n,
    output logic we_n
);
    always_comb begin
        cs_n = 1'b0;
        case (cmd)
            CMD_PREA: {ras_n, cas_n, we_n} = 3'b010;
            CMD_REFA: {ras_n, cas_n, we_n} = 3'b001;
            CMD_MRS:  {ras_n, cas_n, we_n} = 3'b000;
            default:  {ras_n, cas_n, we_n} = 3'b111;
        endcase
    end
endmodule

// File: rtl/sdinit_ref_sched.sv
module sdinit_ref_sched #(
    parameter int INTERVAL = 780,
    parameter int MISS_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic serve,
    output logic pend_nz,
    output logic overrun
);
    localparam int IW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam int PW = $clog2(MISS_MAX + 1);

    typedef struct packed {
        logic [IW-1:0] icnt;
        logic [PW-1:0] pend;
        logic          ovr;
    } sched_t;

    sched_t q, d;
    logic   tick;

    always_comb begin
        d    = q;
        tick = 1'b0;
        if (!enable) begin
            d.icnt = IW'(INTERVAL - 1);
        end else if (q.icnt == '0) begin
            tick   = 1'b1;
            d.icnt = IW'(INTERVAL - 1);
        end else begin
            d.icnt = q.icnt - 1'b1;
        end
        case ({tick, serve})
            2'b10: begin
                if (q.pend == PW'(MISS_MAX)) d.ovr  = 1'b1;
                else                         d.pend = q.pend + 1'b1;
            end
            2'b01:   d.pend = q.pend - 1'b1;
            default: d.pend = q.pend;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.icnt <= IW'(INTERVAL - 1);
            q.pend <= '0;
            q.ovr  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign pend_nz = (q.pend != '0);
    assign overrun = q.ovr;

    // R11: the overrun flag never clears without reset
    a_r11_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q.ovr |=> q.ovr);
    // R10: the backlog never exceeds its limit
    a_r10_pend_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.pend <= PW'(MISS_MAX));
    // R10: a grant is served only against an owed refresh
    a_r10_serve_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        serve |-> q.pend != '0);
endmodule

// File: rtl/sdram_bringup.sv
module sdram_bringup
    import sdinit_pkg::*;
#(
    parameter int ADDR_W       = 13,
    parameter int BA_W         = 2,
    parameter int DQM_W        = 8,
    parameter int STAB_CYC     = 20000,
    parameter int TRP_CYC      = 2,
    parameter int TRFC_CYC     = 7,
    parameter int TRSC_CYC     = 2,
    parameter int INIT_REFS    = 8,
    parameter int REF_INTERVAL = 780,
    parameter int MISS_MAX     = 8,
    parameter int MODE_BITS    = 10,
    parameter logic [MODE_BITS-1:0] MODE_VALUE = 10'h032
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_gnt,
    output logic              cmd_cs_n,
    output logic              cmd_ras_n,
    output logic              cmd_cas_n,
    output logic              cmd_we_n,
    output logic              cmd_cke,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [BA_W-1:0]   cmd_ba,
    output logic [DQM_W-1:0]  cmd_dqm,
    output logic              ready,
    output logic              ref_req,
    output logic              ref_overrun
);
    localparam int AP_BIT = 10;
    localparam int MAX_A  = (STAB_CYC > TRP_CYC) ? STAB_CYC : TRP_CYC;
    localparam int MAX_B  = (TRFC_CYC > TRSC_CYC) ? TRFC_CYC : TRSC_CYC;
    localparam int MAX_D  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = $clog2(MAX_D + 1);
    localparam int REF_W  = $clog2(INIT_REFS + 1);

    typedef struct packed {
        state_e            st;
        logic [CNT_W-1:0]  cnt;
        logic [REF_W-1:0]  left;
        cmd_e              cmd;
        logic [ADDR_W-1:0] addr;
        logic              rdy;
    } ctl_t;

    ctl_t q, d;
    logic pend_nz;
    logic grant_ok;

    assign ref_req  = pend_nz && (q.st == ST_RUN);
    assign grant_ok = ref_req && ref_gnt;

    always_comb begin
        d      = q;
        d.cmd  = CMD_NOP;
        d.addr = '0;
        case (q.st)
            ST_STAB: begin
                if (q.cnt == '0) begin
                    d.cmd          = CMD_PREA;
                    d.addr[AP_BIT] = 1'b1;
                    d.st           = ST_PRE_WAIT;
                    d.cnt          = CNT_W'(TRP_CYC - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_PRE_WAIT: begin
                if (q.cnt == '0) begin
                    d.cmd  = CMD_REFA;
                    d.st   = ST_REF_WAIT;
                    d.cnt  = CNT_W'(TRFC_CYC - 1);
                    d.left = REF_W'(INIT_REFS - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_REF_WAIT: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else if (q.left != '0) begin
                    d.cmd  = CMD_REFA;
                    d.left = q.left - 1'b1;
                    d.cnt  = CNT_W'(TRFC_CYC - 1);
                end else begin
                    d.cmd                  = CMD_MRS;
                    d.addr[MODE_BITS-1:0]  = MODE_VALUE;
                    d.st                   = ST_MRS_WAIT;
                    d.cnt                  = CNT_W'(TRSC_CYC - 1);
                end
            end
            ST_MRS_WAIT: begin
                if (q.cnt == '0) begin
                    d.st  = ST_RUN;
                    d.rdy = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_RUN: begin
                if (grant_ok) begin
                    d.cmd = CMD_REFA;
                    d.st  = ST_RUN_REC;
                    d.cnt = CNT_W'(TRFC_CYC - 1);
                end
            end
            ST_RUN_REC: begin
                if (q.cnt == '0) d.st  = ST_RUN;
                else             d.cnt = q.cnt - 1'b1;
            end
            default: d.st = ST_STAB;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_STAB;
            q.cnt  <= CNT_W'(STAB_CYC - 1);
            q.left <= '0;
            q.cmd  <= CMD_NOP;
            q.addr <= '0;
            q.rdy  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    sdinit_cmd_enc u_enc (
        .cmd   (q.cmd),
        .cs_n  (cmd_cs_n),
        .ras_n (cmd_ras_n),
        .cas_n (cmd_cas_n),
        .we_n  (cmd_we_n)
    );

    sdinit_ref_sched #(
        .INTERVAL (REF_INTERVAL),
        .MISS_MAX (MISS_MAX)
    ) u_sched (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (q.rdy),
        .serve   (grant_ok),
        .pend_nz (pend_nz),
        .overrun (ref_overrun)
    );

    assign cmd_cke  = 1'b1;
    assign cmd_addr = q.addr;
    assign cmd_ba   = '0;
    assign cmd_dqm  = {DQM_W{~q.rdy}};
    assign ready    = q.rdy;

    // R9: an accepted grant yields a refresh command next cycle
    a_r9_grant_gives_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req && ref_gnt |=> q.cmd == CMD_REFA);
    // R9: no new request while a running-mode refresh recovers
    a_r9_no_req_in_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        q.cmd == CMD_REFA && q.rdy |-> !ref_req);
    // R8: an unanswered request is held
    a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req && !ref_gnt |=> ref_req);
    // R6: ready stays up until reset
    a_r6_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q.rdy |=> q.rdy);
    // R12: once running, only a granted request produces a command
    a_r12_quiet_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
        q.rdy && !(ref_req && ref_gnt) |=> q.cmd == CMD_NOP);
    // R5: the mode load is followed by the settle wait, never by ready at once
    a_r5_mrs_then_wait: assert property (@(posedge clk) disable iff (!rst_n)
        q.cmd == CMD_MRS |-> !q.rdy);
endmodule

// File: tb/sdram_bringup_bench.sv
`timescale 1ns/1ps
module sdram_bringup_bench;
    localparam int ADDR_W = 13;
    localparam int BA_W   = 2;
    localparam int DQM_W  = 8;
    localparam int STAB   = 20;
    localparam int TRP    = 3;
    localparam int TRFC   = 5;
    localparam int TRSC   = 2;
    localparam int NREF   = 8;
    localparam int RI     = 60;
    localparam int MMAX   = 8;
    localparam logic [9:0] MODE = 10'h032;

    localparam int P_PRE = STAB;
    localparam int P_REF = STAB + TRP;
    localparam int P_MRS = P_REF + NREF * TRFC;
    localparam int P_RDY = P_MRS + TRSC;

    localparam int C_NOP = 0, C_PREA = 1, C_REFA = 2, C_MRS = 3, C_BAD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_gnt = 1'b0;
    logic cs_n, ras_n, cas_n, we_n, cke, ready, ref_req, ovr;
    logic [ADDR_W-1:0] addr;
    logic [BA_W-1:0]   ba;
    logic [DQM_W-1:0]  dqm;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int cyc;

    always #5 clk = ~clk;

    always @(posedge clk or negedge rst_n)
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;

    sdram_bringup #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .DQM_W(DQM_W), .STAB_CYC(STAB),
        .TRP_CYC(TRP), .TRFC_CYC(TRFC), .TRSC_CYC(TRSC), .INIT_REFS(NREF),
        .REF_INTERVAL(RI), .MISS_MAX(MMAX), .MODE_BITS(10), .MODE_VALUE(MODE)
    ) u_sdram_bringup (
        .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt),
        .cmd_cs_n(cs_n), .cmd_ras_n(ras_n), .cmd_cas_n(cas_n), .cmd_we_n(we_n),
        .cmd_cke(cke), .cmd_addr(addr), .cmd_ba(ba), .cmd_dqm(dqm),
        .ready(ready), .ref_req(ref_req), .ref_overrun(ovr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int dec();
        if (cs_n !== 1'b0) return C_BAD;
        case ({ras_n, cas_n, we_n})
            3'b111:  return C_NOP;
            3'b010:  return C_PREA;
            3'b001:  return C_REFA;
            3'b000:  return C_MRS;
            default: return C_BAD;
        endcase
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
    endtask

    function automatic int exp_init(input int k);
        if (k == P_PRE) return C_PREA;
        if (k == P_MRS) return C_MRS;
        if (k >= P_REF && k < P_MRS && ((k - P_REF) % TRFC) == 0) return C_REFA;
        return C_NOP;
    endfunction

    // R1, R13: reset state at the pins
    task automatic t_reset_state(input string tag);
        chk(dec() == C_NOP, {tag, " reset cmd NOP"}, dec(), C_NOP);
        chk(cke === 1'b1, {tag, " reset cke"}, cke, 1);
        chk(dqm === '1, {tag, " reset dqm"}, dqm, 255);
        chk(ready === 1'b0, {tag, " reset ready"}, ready, 0);
        chk(ref_req === 1'b0, {tag, " reset ref_req"}, ref_req, 0);
        chk(ovr === 1'b0, {tag, " reset overrun"}, ovr, 0);
    endtask

    // R2..R7 (and R12 when stray is set): full bring-up schedule
    task automatic t_init(input bit stray);
        ref_gnt = stray;
        rst_n = 1'b0;
        step();
        t_reset_state("R1");
        do_reset();
        for (int k = 1; k <= P_RDY + 2; k++) begin
            int e;
            step();
            e = exp_init(k);
            if (e == C_PREA) begin
                chk(dec() == e, "R2 precharge slot", dec(), e);
                chk(addr[10] === 1'b1, "R2 all-bank bit", addr[10], 1);
            end else if (e == C_MRS) begin
                chk(dec() == e, "R5 mode load slot", dec(), e);
                chk(addr === ADDR_W'(MODE), "R5 mode word", addr, MODE);
                chk(ba === '0, "R5 bank zero", ba, 0);
            end else if (e == C_REFA) begin
                chk(dec() == e, (k == P_REF) ? "R3 first refresh" : "R4 refresh slot", dec(), e);
            end else begin
                chk(dec() == e, stray ? "R12 nop with stray grant" : "R2 nop slot", dec(), e);
            end
            chk(cke === 1'b1, "R7 cke high", cke, 1);
            chk(ready === (k >= P_RDY), "R6 ready timing", ready, k >= P_RDY);
            chk(dqm === ((k >= P_RDY) ? '0 : '1), "R6 mask release", dqm, (k >= P_RDY) ? 0 : 255);
        end
        ref_gnt = 1'b0;
    endtask

    task automatic t_stray_grant();
        t_init(1'b1);
        ref_gnt = 1'b1;
        while (cyc < P_RDY + RI - 2) begin
            step();
            chk(dec() == C_NOP, "R12 grant without request", dec(), C_NOP);
            chk(ref_req === 1'b0, "R12 no early request", ref_req, 0);
        end
        ref_gnt = 1'b0;
        while (cyc < P_RDY + RI) step();
        chk(ref_req === 1'b1, "R12 schedule unchanged", ref_req, 1);
    endtask

    task automatic t_single_grant();
        t_init(1'b0);
        while (cyc < P_RDY + RI - 1) step();
        chk(ref_req === 1'b0, "R8 request not yet due", ref_req, 0);
        step();
        chk(ref_req === 1'b1, "R8 request due", ref_req, 1);
        repeat (3) step();
        chk(ref_req === 1'b1, "R8 request held", ref_req, 1);
        ref_gnt = 1'b1;
        step();
        ref_gnt = 1'b0;
        chk(dec() == C_REFA, "R9 refresh after grant", dec(), C_REFA);
        chk(ref_req === 1'b0, "R9 request dropped", ref_req, 0);
        for (int i = 0; i < TRFC; i++) begin
            step();
            chk(dec() == C_NOP, "R9 single refresh", dec(), C_NOP);
        end
        while (cyc < P_RDY + 2 * RI - 1) step();
        chk(ref_req === 1'b0, "R10 backlog empty", ref_req, 0);
        step();
        chk(ref_req === 1'b1, "R8 second period", ref_req, 1);
    endtask

    task automatic t_backlog();
        int n;
        int first;
        int second;
        t_init(1'b0);
        while (cyc < P_RDY + 3 * RI) step();
        ref_gnt = 1'b1;
        n = 0;
        first = 0;
        second = 0;
        while (cyc < P_RDY + 4 * RI - 2) begin
            step();
            if (dec() == C_REFA) begin
                n++;
                if (n == 1) first = cyc;
                if (n == 2) second = cyc;
            end
        end
        ref_gnt = 1'b0;
        chk(n == 3, "R10 three owed refreshes served", n, 3);
        chk(second - first == TRFC + 1, "R9 running refresh spacing", second - first, TRFC + 1);
        chk(ref_req === 1'b0, "R10 request clear after backlog", ref_req, 0);
    endtask

    task automatic t_overrun();
        int n;
        t_init(1'b0);
        while (cyc < P_RDY + 9 * RI - 1) step();
        chk(ovr === 1'b0, "R11 no overrun at limit", ovr, 0);
        step();
        chk(ovr === 1'b1, "R11 overrun raised", ovr, 1);
        ref_gnt = 1'b1;
        n = 0;
        while (cyc < P_RDY + 9 * RI + 55) begin
            step();
            if (dec() == C_REFA) n++;
        end
        ref_gnt = 1'b0;
        chk(n == MMAX, "R10 saturated backlog served", n, MMAX);
        chk(ref_req === 1'b0, "R10 request clear", ref_req, 0);
        chk(ovr === 1'b1, "R11 overrun sticky", ovr, 1);
    endtask

    task automatic t_mid_reset();
        t_init(1'b0);
        do_reset();
        while (cyc < P_REF + 2 * TRFC + 1) step();
        rst_n = 1'b0;
        #1;
        t_reset_state("R13");
        t_init(1'b0);
    endtask

    initial begin
        t_stray_grant();
        t_single_grant();
        t_backlog();
        t_overrun();
        t_mid_reset();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_900_000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule